// File: doc/BRIEF.md
# Angle Converter Two-Word Parallel Reader

This block sits on the host side of a parallel port that connects to an external angle-tracking converter. When the host asks for a reading, the block freezes one snapshot in the converter with an active-low sample strobe. It then waits out the converter's internal transfer time and reads two 12-bit words through one chip-select window. The position word is read first and the velocity word second. A word-select line picks which register the converter drives onto the bus.

All spacings are counted in system-clock cycles. They are derived at elaboration from the system clock frequency and the slowest converter clock the board may use, and each minimum is rounded up. Both words are returned on dedicated outputs. They hold their value until the next reading completes, and a one-cycle done pulse marks their update. Start requests that arrive while a reading is in flight are dropped.

Top module: `conv_read_seq`

## Requirements
- R1: After reset, sample_n, cs_n and rd_n are high, sel_pos is high, done is low, and pos_word and vel_word are zero.
- R2: A start accepted in the idle state drives sample_n low on the next clock edge. It stays low for SAMPLE_CYC = ceil((2 converter periods + 20 ns) / system period) cycles, which is 18 cycles at 50 MHz with a 6.144 MHz converter clock.
- R3: cs_n falls exactly GAP_CYC = ceil((6 converter periods + 20 ns) / system period) cycles after sample_n returns high, which is 50 cycles at the defaults. sample_n and cs_n are never low together.
- R4: rd_n first falls SETUP_CYC = ceil(5 ns / system period) cycles after cs_n falls (1 at the defaults). sel_pos is 1 (position) throughout the first rd_n low pulse and 0 (velocity) throughout the second. It changes only while rd_n is high.
- R5: Each rd_n low pulse lasts STROBE_CYC = ceil(max(30 ns, 18 ns) / system period) cycles (2 at the defaults). The bus is captured on the clock edge that ends the pulse, so data that becomes valid 30 ns after rd_n falls is taken.
- R6: Between the two read strobes, rd_n stays high for REC_CYC = max(ceil(18 ns / period), SETUP_CYC) cycles (1 at the defaults).
- R7: The word captured in the first read appears on pos_word and the word from the second read appears on vel_word. Both hold until the next completed reading.
- R8: cs_n returns high one cycle after the second rd_n rise. done is high for exactly that one cycle, together with cs_n going high.
- R9: start is ignored from the cycle it is accepted through the done cycle. If start is held high, the next sample_n fall occurs two cycles after done rises.
- R10: rd_n is low only while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one two-word reading |
| bus_in | input | 12 | Converter data bus |
| sample_n | output | 1 | Active-low snapshot strobe to converter |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| sel_pos | output | 1 | Word select: 1 position, 0 velocity |
| pos_word | output | 12 | Last captured position word |
| vel_word | output | 12 | Last captured velocity word |
| done | output | 1 | One-cycle pulse when both words are updated |

## Verification
The hardest condition to reach from the ports is capture timing, because a converter that answers instantly hides a design that samples the bus too early. The bench therefore models the bus as invalid until 30 ns after rd_n falls, and shows a distinct filler value otherwise. An early capture then returns the filler instead of the word. Start requests are also injected mid-sequence and exactly in the done cycle to reach the ignore window at both of its edges.

// File: rtl/conv_read_seq.sv
module conv_read_seq #(
  parameter int DW           = 12,
  parameter int SYS_CLK_KHZ  = 50000,
  parameter int CONV_CLK_KHZ = 6144
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] bus_in,
  output logic          sample_n,
  output logic          cs_n,
  output logic          rd_n,
  output logic          sel_pos,
  output logic [DW-1:0] pos_word,
  output logic [DW-1:0] vel_word,
  output logic          done
);
  localparam longint SYS_PS  = 64'd1000000000 / SYS_CLK_KHZ;
  localparam longint CONV_PS = (64'd1000000000 + CONV_CLK_KHZ - 1) / CONV_CLK_KHZ;

  function automatic int cyc(input longint ps);
    longint c;
    c = (ps + SYS_PS - 1) / SYS_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int SAMPLE_CYC = cyc(2 * CONV_PS + 20000);
  localparam int GAP_CYC    = cyc(6 * CONV_PS + 20000);
  localparam int SETUP_CYC  = cyc(5000);
  localparam int STROBE_CYC = cyc(30000);
  localparam int REC_CYC    = (cyc(18000) > SETUP_CYC) ? cyc(18000) : SETUP_CYC;
  localparam int CW         = $clog2(SAMPLE_CYC + GAP_CYC + 2);

  typedef enum logic [3:0] {
    IDLE, SAMP, GAP, SET1, RD1, REC, RD2, REL, FIN
  } st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt, nlen;

  always_comb begin
    nxt = IDLE;
    unique case (st)
      IDLE:    nxt = SAMP;
      SAMP:    nxt = GAP;
      GAP:     nxt = SET1;
      SET1:    nxt = RD1;
      RD1:     nxt = REC;
      REC:     nxt = RD2;
      RD2:     nxt = REL;
      REL:     nxt = FIN;
      default: nxt = IDLE;
    endcase
    unique case (nxt)
      SAMP:      nlen = CW'(SAMPLE_CYC - 1);
      GAP:       nlen = CW'(GAP_CYC - 1);
      SET1:      nlen = CW'(SETUP_CYC - 1);
      RD1, RD2:  nlen = CW'(STROBE_CYC - 1);
      REC:       nlen = CW'(REC_CYC - 1);
      default:   nlen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      pos_word <= '0;
      vel_word <= '0;
    end else if (st == IDLE) begin
      if (start) begin
        st  <= nxt;
        cnt <= nlen;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      if (st == RD1) pos_word <= bus_in;
      if (st == RD2) vel_word <= bus_in;
      st  <= nxt;
      cnt <= nlen;
    end
  end

  assign sample_n = (st != SAMP);
  assign cs_n     = !(st inside {SET1, RD1, REC, RD2, REL});
  assign rd_n     = !(st inside {RD1, RD2});
  assign sel_pos  = !(st inside {REC, RD2, REL});
  assign done     = (st == FIN);

  AST_RD_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n); // R10
  AST_SAMPLE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_n |-> cs_n); // R3
  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !$past(rd_n)) |-> $stable(sel_pos)); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && rd_n && sample_n)); // R8
  AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && $past(rd_n)) |-> ($stable(pos_word) && $stable(vel_word))); // R7
endmodule

// File: tb/conv_read_seq_test.sv
`timescale 1ns/1ps
module conv_read_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] bus_in;
  logic        sample_n, cs_n, rd_n, sel_pos, done;
  logic [11:0] pos_word, vel_word;
  logic [11:0] pos_pat = 12'h000, vel_pat = 12'h000;
  logic        bus_ok = 1'b0;
  int          checks = 0, errors = 0;

  localparam logic [11:0] FILL = 12'hEEE;
  localparam logic [23:0] VEC [5] = '{24'h123ABC, 24'h000FFF, 24'hFFF000,
                                      24'h5A5A5A, 24'h801001};

  always #10 clk = ~clk;

  conv_read_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_in(bus_in),
    .sample_n(sample_n), .cs_n(cs_n), .rd_n(rd_n), .sel_pos(sel_pos),
    .pos_word(pos_word), .vel_word(vel_word), .done(done)
  );

  always @(rd_n) begin
    bus_ok = 1'b0;
    if (rd_n === 1'b0) begin
      #30;
      if (rd_n === 1'b0) bus_ok = 1'b1;
    end
  end

  assign bus_in = (!cs_n && !rd_n && bus_ok) ? (sel_pos ? pos_pat : vel_pat) : FILL;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run_seq(input logic [11:0] p, input logic [11:0] v, input bit poke);
    int s0 = -1, s1 = -1, c0 = -1, r0 = -1, r1 = -1, r2 = -1, r3 = -1, c1 = -1, d = -1;
    int dcnt = 0;
    bit sel1_bad = 0, sel2_bad = 0, rd_no_cs = 0, samp_cs = 0, restarted = 0;
    pos_pat = p;
    vel_pat = v;
    start = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 120; i++) begin
      if (!sample_n && s0 < 0) s0 = i;
      if (sample_n && s0 >= 0 && s1 < 0) s1 = i;
      if (!cs_n && c0 < 0) c0 = i;
      if (cs_n && c0 >= 0 && c1 < 0) c1 = i;
      if (r0 < 0) begin
        if (!rd_n) begin r0 = i; if (!sel_pos) sel1_bad = 1; end
      end else if (r1 < 0) begin
        if (rd_n) r1 = i; else if (!sel_pos) sel1_bad = 1;
      end else if (r2 < 0) begin
        if (!rd_n) begin r2 = i; if (sel_pos) sel2_bad = 1; end
      end else if (r3 < 0) begin
        if (rd_n) r3 = i; else if (sel_pos) sel2_bad = 1;
      end
      if (!rd_n && cs_n) rd_no_cs = 1;
      if (!sample_n && !cs_n) samp_cs = 1;
      if (done) begin dcnt++; if (d < 0) d = i; end
      if (d >= 0 && i > d && !sample_n) restarted = 1;
      start = poke && (i == 30 || i == d);
      @(negedge clk);
    end
    start = 1'b0;
    chk(s1 - s0 == 18, "R2 sample low width", s1 - s0, 18);
    chk(c0 - s1 == 50, "R3 sample to cs gap", c0 - s1, 50);
    chk(!samp_cs, "R3 sample and cs overlap", samp_cs, 0);
    chk(r0 - c0 == 1, "R4 cs to first rd", r0 - c0, 1);
    chk(!sel1_bad, "R4 sel high in position read", sel1_bad, 0);
    chk(!sel2_bad, "R4 sel low in velocity read", sel2_bad, 0);
    chk(r1 - r0 == 2, "R5 first strobe width", r1 - r0, 2);
    chk(r3 - r2 == 2, "R5 second strobe width", r3 - r2, 2);
    chk(r2 - r1 == 1, "R6 recovery between reads", r2 - r1, 1);
    chk(pos_word == p, "R7 position word", pos_word, p);
    chk(vel_word == v, "R7 velocity word", vel_word, v);
    chk(c1 - r3 == 1, "R8 cs release after strobe", c1 - r3, 1);
    chk(d == c1, "R8 done with cs release", d, c1);
    chk(dcnt == 1, "R8 done pulse count", dcnt, 1);
    chk(!rd_no_cs, "R10 rd without cs", rd_no_cs, 0);
    if (poke) chk(!restarted, "R9 start during busy or done", restarted, 0);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    int fall;
    repeat (3) @(negedge clk);
    chk(sample_n && cs_n && rd_n, "R1 strobes idle high", {sample_n, cs_n, rd_n}, 7);
    chk(sel_pos && !done, "R1 sel high done low", {sel_pos, done}, 2);
    chk(pos_word == 0 && vel_word == 0, "R1 words zero", {pos_word, vel_word}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 5; k++) run_seq(VEC[k][23:12], VEC[k][11:0], 1'b0);

    run_seq(12'h3C7, 12'hC38, 1'b1);

    pos_pat = 12'h111;
    vel_pat = 12'h222;
    repeat (6) @(negedge clk);
    chk(pos_word == 12'h3C7 && vel_word == 12'hC38, "R7 words held while idle",
        {pos_word, vel_word}, {12'h3C7, 12'hC38});

    start = 1'b1;
    d = -1;
    fall = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done && d < 0) d = i;
      if (d >= 0 && i > d && !sample_n && fall < 0) fall = i;
    end
    start = 1'b0;
    chk(fall - d == 2, "R9 held start restart spacing", fall - d, 2);
    repeat (150) @(negedge clk);
    chk(pos_word == 12'h111 && vel_word == 12'h222, "R7 words after held start",
        {pos_word, vel_word}, {12'h111, 12'h222});

    rst_n = 1'b0;
    @(negedge clk);
    chk(pos_word == 0 && vel_word == 0 && cs_n && sel_pos, "R1 reset clears",
        {pos_word, vel_word}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule